// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block turns one read request from the processor side of a bus controller into the command sequence that a synchronous DRAM needs for a four-beat burst read. A request carries a bank number, a row and a column. The request is taken through a valid/ready handshake.

After it accepts a request, the sequencer goes through these phases in order:
- It opens the row.
- It waits out a configurable row-to-column delay, filling the gap with no-operation commands.
- It issues a read with auto-precharge.
- It passes four data beats from the memory bus to its output, each with a valid strobe.
- It idles through one or two end-of-read cycles, depending on the clock-ratio setting.

Each bank has its own countdown for the precharge window. A new request to a bank that is still precharging is held off. A request to the other bank may start at once.

Configuration inputs choose the row-to-column delay, the length of the precharge window and the clock-ratio mode. They are expected to stay stable while a burst is in flight.

Top module: `sdram_rd_seq`

## Requirements
- R1: `req_ready` is high only while no burst is in flight and the requested bank's precharge window has ended. In the cycle after a request is accepted, the command lines carry ACTIVATE (cs_n,ras_n,cas_n,we_n = 0011), the row is on the low bits of `sd_addr` and the bank is on `sd_ba`.
- R2: The READ command comes 1, 2 or 3 cycles after the ACTIVATE cycle, for `cfg_rcd` = 00, 01 or 10. A request accepted with `cfg_rcd` = 11 is illegal.
- R3: Every cycle between ACTIVATE and READ carries NOP (0111). While no burst is in flight the lines carry deselect (1111).
- R4: The READ cycle carries 0101, the same bank as the ACTIVATE, the column on the low bits of `sd_addr`, and address bit 10 high to request auto-precharge.
- R5: In the four cycles right after READ, `rd_valid` is high and `rd_data` equals `sd_dq` of that same cycle. The command lines carry NOP. `rd_valid` is low at all other times.
- R6: After the fourth beat come end-of-read cycles carrying NOP: one cycle when `cfg_ratio_1to1` is high, two when it is low. `rd_done` pulses for one cycle, in the last of these cycles.
- R7: After `rd_done`, the bank just read stays unavailable (`req_ready` low for it) for `cfg_rp`+1 cycles. `cfg_rp` values 00, 01, 10 and 11 give 1, 2, 3 and 4 cycles.
- R8: In the cycle right after `rd_done`, a request to the other bank is ready and is accepted without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rcd | input | 2 | Row-to-column delay select |
| cfg_rp | input | 2 | Precharge window length select |
| cfg_ratio_1to1 | input | 1 | High for a 1:1 core-to-bus clock ratio |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_ba | output | BANK_W | Bank select |
| sd_dq | input | DATA_W | Read data from the memory |
| rd_data | output | DATA_W | Captured beat |
| rd_valid | output | 1 | Beat strobe |
| rd_done | output | 1 | Burst finished |

## Verification
The bench builds the block with its default parameters: two banks, a 13-bit address, a 9-bit column and 32-bit beats. The column field ends below address bit 10, so the bench can check the auto-precharge flag and the column separately. With two banks, the bench can start a request to the idle bank in the first cycle of the other bank's precharge window. It then measures the lockout of the bank just read for every `cfg_rp` setting. Every legal row-to-column delay is run under both clock-ratio modes.

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int BANK_W = 1,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_rcd,
  input  logic [1:0]        cfg_rp,
  input  logic              cfg_ratio_1to1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  input  logic [DATA_W-1:0] sd_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_done
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int BUSY_W = 3;
  localparam int AP_BIT = 10;
  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_READ  = 4'b0101;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_GAP, S_RD, S_DATA, S_END} st_t;

  st_t               state;
  logic [1:0]        cnt;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [BUSY_W-1:0] busy [NBANK];
  logic [3:0]        cmd;
  logic              fire, fin;

  assign req_ready = (state == S_IDLE) && (busy[req_bank] == '0);
  assign fire      = req_valid && req_ready;
  assign fin       = (state == S_END) && (cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (fire) begin
          state  <= S_ACT;
          bank_q <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
        end
        S_ACT: begin
          state <= (cfg_rcd == 2'd0) ? S_RD : S_GAP;
          cnt   <= cfg_rcd - 2'd1;
        end
        S_GAP: begin
          if (cnt == 2'd0) state <= S_RD;
          else cnt <= cnt - 2'd1;
        end
        S_RD: begin
          state <= S_DATA;
          cnt   <= 2'd0;
        end
        S_DATA: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            state <= S_END;
            cnt   <= cfg_ratio_1to1 ? 2'd0 : 2'd1;
          end
        end
        S_END: begin
          if (cnt == 2'd0) state <= S_IDLE;
          else cnt <= cnt - 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) busy[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (fin && bank_q == BANK_W'(b))
          busy[b] <= BUSY_W'(cfg_rp) + BUSY_W'(1);
        else if (busy[b] != '0)
          busy[b] <= busy[b] - BUSY_W'(1);
      end
    end
  end

  always_comb begin
    case (state)
      S_IDLE:  cmd = C_DESEL;
      S_ACT:   cmd = C_ACT;
      S_RD:    cmd = C_READ;
      default: cmd = C_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba    = bank_q;
  assign sd_addr  = (state == S_ACT) ? ADDR_W'(row_q) :
                    (state == S_RD)  ? (ADDR_W'(col_q) | (ADDR_W'(1) << AP_BIT)) : '0;
  assign rd_valid = (state == S_DATA);
  assign rd_data  = rd_valid ? sd_dq : '0;
  assign rd_done  = fin;

  assert_act_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_ACT));
  assert_rcd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (cfg_rcd != 2'b11));
  assert_read_autopre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_READ) |-> sd_addr[AP_BIT]);
  assert_beat_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_READ) |=> rd_valid);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  assert_bank_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !(req_ready && req_bank == $past(sd_ba)));
endmodule

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;
  localparam int BANK_W = 1, ROW_W = 13, COL_W = 9, ADDR_W = 13, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_rcd = '0, cfg_rp = '0;
  logic cfg_ratio_1to1 = 1'b1, req_valid = 1'b0, req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ADDR_W-1:0] sd_addr;
  logic [BANK_W-1:0] sd_ba;
  logic [DATA_W-1:0] sd_dq, rd_data;
  logic rd_valid, rd_done;
  logic [15:0] cyc = '0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;
  assign sd_dq = {16'hD00D, cyc};

  sdram_rd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
  u_sdram_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_rcd(cfg_rcd), .cfg_rp(cfg_rp), .cfg_ratio_1to1(cfg_ratio_1to1),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq(sd_dq), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_done(rd_done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic do_read(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [1:0] rcd,
                         input bit ratio, input logic [1:0] rp, output int waited);
    int e;
    e = rcd + 7 + (ratio ? 0 : 1);
    cfg_rcd = rcd; cfg_rp = rp; cfg_ratio_1to1 = ratio;
    req_bank = b; req_row = row; req_col = col; req_valid = 1'b1;
    #1;
    waited = 0;
    while (!req_ready && waited < 20) begin
      waited++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    for (int k = 1; k <= e + 1; k++) begin
      if (k == 1) begin
        chk(cmd_now() == 4'b0011, "R1 activate", cmd_now(), 4'b0011);
        chk(sd_addr == ADDR_W'(row) && sd_ba == b, "R1 row/bank", {sd_ba, sd_addr}, {b, ADDR_W'(row)});
      end else if (k <= rcd + 1) begin
        chk(cmd_now() == 4'b0111, "R3 gap nop", cmd_now(), 4'b0111);
      end else if (k == rcd + 2) begin
        chk(cmd_now() == 4'b0101, "R2/R4 read position", cmd_now(), 4'b0101);
        chk(sd_addr[COL_W-1:0] == col && sd_addr[10] && sd_ba == b, "R4 column/autoprecharge/bank",
            {sd_ba, sd_addr}, {b, ADDR_W'(col) | ADDR_W'(1 << 10)});
      end else if (k <= e) begin
        chk(cmd_now() == 4'b0111, "R5/R6 nop", cmd_now(), 4'b0111);
      end else begin
        chk(cmd_now() == 4'b1111, "R3 idle deselect", cmd_now(), 4'b1111);
      end
      if (k <= e) begin
        chk(rd_valid == (k >= rcd + 3 && k <= rcd + 6), "R5 valid", rd_valid, (k >= rcd + 3 && k <= rcd + 6));
        if (k >= rcd + 3 && k <= rcd + 6)
          chk(rd_data == {16'hD00D, cyc}, "R5 data", rd_data, {16'hD00D, cyc});
        chk(rd_done == (k == e), "R6 done", rd_done, (k == e));
      end
      if (k <= e) begin
        @(negedge clk); #1;
      end
    end
  endtask

  task automatic t_reset();
    chk(cmd_now() == 4'b1111, "R3 reset deselect", cmd_now(), 4'b1111);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(rd_valid == 1'b0 && rd_done == 1'b0, "R5/R6 reset quiet", {rd_valid, rd_done}, 0);
  endtask

  task automatic t_delays();
    int w;
    for (int r = 0; r < 3; r++) begin
      for (int q = 0; q < 2; q++) begin
        do_read(BANK_W'(r & 1), ROW_W'(13'h1A5C + r), COL_W'(9'h0F3 + q), 2'(r), q[0], 2'd0, w);
        repeat (3) @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic t_lockout(input logic [BANK_W-1:0] b, input logic [1:0] rp);
    int w, n;
    do_read(b, 13'h0777, 9'h1AA, 2'd1, 1'b1, rp, w);
    req_bank = ~b; #1;
    chk(req_ready == 1'b1, "R8 other bank ready", req_ready, 1);
    req_bank = b; #1;
    n = 0;
    while (!req_ready && n < 10) begin
      n++;
      @(negedge clk); #1;
    end
    chk(n == rp + 1, "R7 lockout length", n, rp + 1);
  endtask

  task automatic t_other_bank();
    int w;
    do_read(1'b0, 13'h1234, 9'h055, 2'd2, 1'b0, 2'd3, w);
    do_read(1'b1, 13'h0ABC, 9'h1C3, 2'd0, 1'b1, 2'd0, w);
    chk(w == 0, "R8 immediate accept", w, 0);
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_delays();
    for (int p = 0; p < 4; p++) begin
      t_lockout(BANK_W'(p & 1), 2'(p));
      repeat (6) @(negedge clk);
      #1;
    end
    t_other_bank();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule